// File: doc/BRIEF.md
# Shared Sequential Multiply-Divide Unit

This block is an iterative integer arithmetic engine. It forms a full double-width product or a quotient and remainder pair from two single-width operands, with signed and unsigned variants of each. One adder/subtractor and one double-width shift register do the work for every operation, and the unit retires one bit of work per clock.

Multiplication is shift-and-add: the adder result and the shift land in the register on the same edge. Division is restoring, one partial-remainder subtraction per clock. The remainder builds up in the upper half of the register and the quotient bits shift into the lower half. Signed operations run on magnitudes and spend one extra clock on a sign fix-up. Results appear on a HI word and a LO word that hold their value until the next completion.

Operations are issued with a one-cycle `start` pulse while `busy` is low. This is the only flow-control rule: there is no queue, and a `start` that arrives while `busy` is high is dropped without trace. A caller must therefore wait for `done` (or for `busy` to fall) before it issues the next operation. Overflow and zero divisors raise no trap.

Top module: `seq_muldiv`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `hi`, `lo` are 0.
- R2: A `start` sampled while `busy` is 0 is accepted, and `busy` is 1 in the next cycle. A `start` sampled while `busy` is 1 is ignored: the running operation's result and timing are unchanged.
- R3: With `op` = 2'b00 (unsigned multiply), {`hi`,`lo`} equals the 64-bit unsigned product of `a` and `b`.
- R4: With `op` = 2'b01 (signed multiply), {`hi`,`lo`} equals the 64-bit two's-complement product. It is formed by multiplying the magnitudes and negating the product when the operand signs differ.
- R5: With `op` = 2'b10 (unsigned divide), `lo` holds the quotient and `hi` holds the remainder of `a` / `b`.
- R6: With `op` = 2'b11 (signed divide), the quotient is truncated toward zero and is negative when the operand signs differ. The remainder takes the sign of `a`. Both come from dividing the magnitudes.
- R7: A zero divisor, signed or unsigned, completes with normal latency and gives `lo` = all ones and `hi` = `a`.
- R8: `done` is high for exactly one cycle per accepted operation, and `busy` is 0 whenever `done` is 1.
- R9: `hi` and `lo` change only in the cycle in which `done` is 1, and otherwise hold their value.
- R10: `done` rises 32 clock edges after the accepting edge for unsigned operations (op bit 0 = 0) and 33 edges after it for signed operations (op bit 0 = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue pulse, sampled only while `busy` is 0 |
| op | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| a | input | 32 | Multiplicand or dividend |
| b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; `hi`/`lo` valid from here |
| hi | output | 32 | Upper product word or remainder |
| lo | output | 32 | Lower product word or quotient |

## Verification
A corrupted shift register or a wrong adder mode stays hidden until the completion pulse. It then shows as a wrong `hi`/`lo` pair 32 or 33 cycles after issue, so every vector is compared at that pulse. A fault in the iteration counter or the state sequencing shows as a `done` pulse that comes early, comes late or lasts too long. The latency is therefore measured for every operation. A leaky `busy` gate shows only when a second `start` lands mid-operation, and a directed test covers that case.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;
endpackage

// File: rtl/muldiv_prep.sv
// Operand magnitudes and the sign corrections the fix-up cycle must apply.
module muldiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  input  logic         is_div,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_wide,
  output logic         neg_hi,
  output logic         neg_lo
);
  logic sa, sb, b_zero;

  always_comb begin
    sa     = is_signed & a[W-1];
    sb     = is_signed & b[W-1];
    b_zero = (b == '0);
    mag_a  = sa ? (~a + 1'b1) : a;
    mag_b  = sb ? (~b + 1'b1) : b;
    // multiply: negate whole product when signs differ
    neg_wide = !is_div && (sa ^ sb);
    // divide: remainder follows dividend, quotient follows sign xor (not for zero divisor)
    neg_hi   = is_div && sa;
    neg_lo   = is_div && (sa ^ sb) && !b_zero;
  end
endmodule

// File: rtl/muldiv_step.sv
// One iteration of the shared datapath: a single adder that adds for
// multiply and subtracts for divide, followed by the matching shift.
module muldiv_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   m,
  input  logic           is_div,
  output logic [2*W-1:0] nxt
);
  logic [W:0]   x;
  logic [W+1:0] y_ext;
  logic [W+1:0] res;
  logic         qbit;

  always_comb begin
    x     = is_div ? {acc[2*W-1:W], acc[W-1]} : {1'b0, acc[2*W-1:W]};
    y_ext = {2'b00, m};
    res   = {1'b0, x} + (is_div ? ~y_ext : y_ext) + {{(W+1){1'b0}}, is_div};
    qbit  = !res[W+1];
    if (is_div) begin
      if (qbit) nxt = {res[W-1:0], acc[W-2:0], 1'b1};
      else      nxt = {x[W-1:0],   acc[W-2:0], 1'b0};
    end else begin
      if (acc[0]) nxt = {res[W:0], acc[W-1:1]};
      else        nxt = {1'b0, acc[2*W-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_ctrl.sv
// Sequencer: idle, W iterations, optional sign fix-up cycle.
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic signed_q,
  output logic busy,
  output logic load,
  output logic step_en,
  output logic fix_en,
  output logic finish
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  md_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  always_comb begin
    load    = 1'b0;
    step_en = 1'b0;
    fix_en  = 1'b0;
    finish  = 1'b0;
    last    = (cnt_q == LAST);
    case (state_q)
      ST_IDLE: load = start;
      ST_RUN: begin
        step_en = 1'b1;
        finish  = last && !signed_q;
      end
      ST_FIX: begin
        fix_en = 1'b1;
        finish = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) state_q <= signed_q ? ST_FIX : ST_IDLE;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int DW = 2 * W;

  logic [DW-1:0] acc_q, nxt, out_val;
  logic [W-1:0]  m_q, mag_a, mag_b;
  logic          div_q, signed_q, neg_wide_q, neg_hi_q, neg_lo_q;
  logic          neg_wide, neg_hi, neg_lo;
  logic          load, step_en, fix_en, finish;

  muldiv_prep #(.W(W)) u_prep (
    .a(a), .b(b), .is_signed(op[0]), .is_div(op[1]),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_wide(neg_wide), .neg_hi(neg_hi), .neg_lo(neg_lo)
  );

  muldiv_step #(.W(W)) u_step (
    .acc(acc_q), .m(m_q), .is_div(div_q), .nxt(nxt)
  );

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_q(signed_q),
    .busy(busy), .load(load), .step_en(step_en), .fix_en(fix_en),
    .finish(finish)
  );

  // Result source: last iteration directly (unsigned) or sign-corrected register (signed)
  always_comb begin
    if (fix_en) begin
      if (neg_wide_q) begin
        out_val = ~acc_q + 1'b1;
      end else begin
        out_val[DW-1:W] = neg_hi_q ? (~acc_q[DW-1:W] + 1'b1) : acc_q[DW-1:W];
        out_val[W-1:0]  = neg_lo_q ? (~acc_q[W-1:0] + 1'b1)  : acc_q[W-1:0];
      end
    end else begin
      out_val = nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      m_q        <= '0;
      div_q      <= 1'b0;
      signed_q   <= 1'b0;
      neg_wide_q <= 1'b0;
      neg_hi_q   <= 1'b0;
      neg_lo_q   <= 1'b0;
      hi         <= '0;
      lo         <= '0;
      done       <= 1'b0;
    end else begin
      done <= finish;
      if (load) begin
        acc_q      <= {{W{1'b0}}, mag_a};
        m_q        <= mag_b;
        div_q      <= op[1];
        signed_q   <= op[0];
        neg_wide_q <= neg_wide;
        neg_hi_q   <= neg_hi;
        neg_lo_q   <= neg_lo;
      end else if (step_en) begin
        acc_q <= nxt;
      end
      if (finish) begin
        hi <= out_val[DW-1:W];
        lo <= out_val[W-1:0];
      end
    end
  end
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  logic [7:0]   lat_q;
  logic         sgn_q;
  md_op_e       op_q;
  logic [W-1:0] a_q, b_q;
  logic         accept;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
      sgn_q <= 1'b0;
      op_q  <= OP_MULS;
      a_q   <= '0;
      b_q   <= '0;
    end else if (accept) begin
      lat_q <= '0;
      sgn_q <= op[0];
      op_q  <= md_op_e'(op);
      a_q   <= a;
      b_q   <= b;
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_mulu_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MULU) |-> ({hi, lo} == {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q}));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo)));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (sgn_q ? 8'(W + 1) : 8'(W))));
endmodule

bind seq_muldiv muldiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
  .busy(busy), .done(done), .hi(hi), .lo(lo)
);

// File: tb/tb_seq_muldiv.sv
`timescale 1ns/1ps
module tb_seq_muldiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  seq_muldiv dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  // {op, a, b, expected hi, expected lo}
  localparam int NV = 14;
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 32'd7,        32'd6,        32'h0000_0000, 32'h0000_002A},
    {2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001},
    {2'b00, 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'h0000_0000},
    {2'b01, 32'hFFFF_FFFD, 32'd5,        32'hFFFF_FFFF, 32'hFFFF_FFF1},
    {2'b01, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0010},
    {2'b01, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000},
    {2'b10, 32'd100,      32'd7,        32'h0000_0002, 32'h0000_000E},
    {2'b10, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0000_000F, 32'h0FFF_FFFF},
    {2'b10, 32'd3,        32'd9,        32'h0000_0003, 32'h0000_0000},
    {2'b11, 32'hFFFF_FFF9, 32'd2,        32'hFFFF_FFFF, 32'hFFFF_FFFD},
    {2'b11, 32'd7,        32'hFFFF_FFFE, 32'h0000_0001, 32'hFFFF_FFFD},
    {2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000},
    {2'b10, 32'd5,        32'd0,        32'h0000_0005, 32'hFFFF_FFFF},
    {2'b11, 32'hFFFF_FFFB, 32'd0,        32'hFFFF_FFFB, 32'hFFFF_FFFF}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] o, input logic [31:0] d);
    if (o[1] && d == 0) return "R7";
    case (o)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Issue one operation; optionally pulse start again (with other operands)
  // after poke edges. Returns edges from acceptance to done.
  task automatic run_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                        input int poke, output int lat, output logic ok);
    int n;
    @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    n = 0; ok = 1'b0;
    for (int i = 0; i < 100 && !ok; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke != 0 && n == poke) begin
        start = 1'b1; a = 32'h1234_5678; b = 32'h0000_0003; op = ~o;
      end else begin
        start = 1'b0;
      end
      if (done) ok = 1'b1;
    end
    start = 1'b0;
    lat = n - 1;
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int lat;
    logic ok;
    logic [63:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", {busy, done, hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, busy, done}, 64'd0);

    // Vector table: R3..R7 values and R10 latency
    foreach (VEC[k]) begin
      logic [1:0]  vo;
      logic [31:0] va, vb, eh, el;
      {vo, va, vb, eh, el} = VEC[k];
      run_op(vo, va, vb, 0, lat, ok);
      check(req_of(vo, vb), {hi, lo}, {eh, el});
      check("R10", 64'(lat), vo[0] ? 64'd33 : 64'd32);
      check("R8", {63'd0, ok && !busy}, 64'd1);
    end

    // R8: done lasts one cycle
    @(negedge clk);
    check("R8", {62'd0, done, busy}, 64'd0);

    // R2: accepted start raises busy next cycle
    @(negedge clk);
    op = 2'b00; a = 32'd9; b = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {63'd0, busy}, 64'd1);
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);

    // R2: start while busy is ignored (result and latency from first op)
    run_op(2'b00, 32'd1000, 32'd3000, 6, lat, ok);
    check("R2", {hi, lo}, 64'd3000000);
    check("R2", 64'(lat), 64'd32);
    @(negedge clk);
    check("R2", {62'd0, busy, done}, 64'd0);

    // R9: outputs hold with changed inputs and no start
    held = {hi, lo};
    op = 2'b11; a = 32'hDEAD_BEEF; b = 32'd17;
    repeat (5) @(negedge clk);
    check("R9", {hi, lo}, held);
    check("R9", {62'd0, busy, done}, 64'd0);

    // R9: during a run the old result is kept until done
    @(negedge clk);
    op = 2'b10; a = 32'd50; b = 32'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check("R9", {hi, lo}, held);
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    check("R5", {hi, lo}, {32'd2, 32'd6});

    finish_up();
  end
endmodule